// File: doc/BRIEF.md
# Alarm Clock Mode and Adjustment Controller

This block is the button front end of a digital alarm clock. Three push buttons come in: a mode button that steps through the operating modes, an adjust button that advances the field currently selected, and a home button that returns to plain timekeeping. Each button passes through a synchronizer and a rising-edge detector, so one press acts exactly once however long it is held.

The controller has six modes. In the order a mode press visits them they are: run (normal display), time hours, time minutes, time seconds, alarm hours and alarm minutes. A mode press from alarm minutes goes back to run. In each adjust mode an adjust press produces a one-cycle increment pulse on the line for that field only. The counters that receive these pulses sit outside the block. Per-field flash flags tell the display which digits to blank at its blink rate. A display-source select chooses the alarm registers while an alarm field is being set. All outputs are plain level or pulse signals. There is no data stream, so no valid/ready handshake applies.

Top module: `clkui_ctrl`

## Requirements
- R1: While `rst` is high and after it falls, the mode is run: every increment output, every flash flag and `show_alarm` are low.
- R2: Each mode press advances the mode one step in the order run, time hours, time minutes, time seconds, alarm hours, alarm minutes. From alarm minutes it wraps to run.
- R3: A home press returns to run from any mode. If home and mode are pressed in the same cycle, home wins and the mode ends in run.
- R4: An adjust press in an adjust mode raises exactly one increment line for exactly one cycle. The mapping is time hours to `inc_time_hr`, time minutes to `inc_time_min`, time seconds to `inc_time_sec`, alarm hours to `inc_alarm_hr` and alarm minutes to `inc_alarm_min`. The pulse is high in the third clock cycle after the raw button input rises.
- R5: An adjust press in run mode produces no increment pulse.
- R6: A button held high for many cycles acts once. The increment line is low again the cycle after its pulse, and the mode does not step again while the button stays held.
- R7: `flash_hr` is high in time hours and alarm hours. `flash_min` is high in time minutes and alarm minutes. `flash_sec` is high in time seconds only. All three flags are low in run.
- R8: `show_alarm` is high in alarm hours and alarm minutes and low in the other four modes.
- R9: If adjust and mode are pressed in the same cycle, the increment goes to the field of the mode in effect before the step.
- R10: If home and adjust are pressed in the same cycle, no increment pulse is produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| btn_mode | input | 1 | Raw mode-step button |
| btn_adj | input | 1 | Raw adjust button |
| btn_home | input | 1 | Raw return-to-run button |
| inc_time_hr | output | 1 | One-cycle increment for time hours |
| inc_time_min | output | 1 | One-cycle increment for time minutes |
| inc_time_sec | output | 1 | One-cycle increment for time seconds |
| inc_alarm_hr | output | 1 | One-cycle increment for alarm hours |
| inc_alarm_min | output | 1 | One-cycle increment for alarm minutes |
| flash_hr | output | 1 | Blink hour digits |
| flash_min | output | 1 | Blink minute digits |
| flash_sec | output | 1 | Blink second digits |
| show_alarm | output | 1 | Display shows the alarm time when high |

## Verification
A raw button edge passes two synchronizer flops and then the state and increment registers. With the default two stages, the new mode, its flags and any increment pulse appear after the third rising clock edge that follows the input change. The bench drives buttons on a falling edge and counts exactly three rising edges. It then samples on the next falling edge and compares with a bench model of mode and pulse. One cycle later it samples again to confirm the pulse has dropped while the button is still held.

// File: rtl/clkui_pkg.sv
package clkui_pkg;
  typedef enum logic [2:0] {
    MODE_RUN   = 3'd0,
    MODE_T_HR  = 3'd1,
    MODE_T_MIN = 3'd2,
    MODE_T_SEC = 3'd3,
    MODE_A_HR  = 3'd4,
    MODE_A_MIN = 3'd5
  } clk_mode_e;

  localparam int NUM_BTN    = 3;
  localparam int BTN_MODE   = 0;
  localparam int BTN_ADJ    = 1;
  localparam int BTN_HOME   = 2;
  localparam int NUM_FIELDS = 5;
endpackage

// File: rtl/clkui_btn_cond.sv
module clkui_btn_cond #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic btn_raw,
  output logic press
);
  logic [STAGES:0] shift_q;

  always_ff @(posedge clk) begin
    if (rst) shift_q <= '0;
    else     shift_q <= {shift_q[STAGES-1:0], btn_raw};
  end

  // rising edge of the synchronized level
  assign press = shift_q[STAGES-1] & ~shift_q[STAGES];
endmodule

// File: rtl/clkui_mode_fsm.sv
module clkui_mode_fsm
  import clkui_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      step,
  input  logic      home,
  output clk_mode_e mode
);
  clk_mode_e mode_q, mode_d;

  always_comb begin
    mode_d = mode_q;
    if (home) begin
      mode_d = MODE_RUN;
    end else if (step) begin
      if (mode_q == MODE_A_MIN) mode_d = MODE_RUN;
      else                      mode_d = clk_mode_e'(mode_q + 3'd1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) mode_q <= MODE_RUN;
    else     mode_q <= mode_d;
  end

  assign mode = mode_q;
endmodule

// File: rtl/clkui_out_decode.sv
module clkui_out_decode
  import clkui_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  clk_mode_e             mode,
  input  logic                  adj,
  input  logic                  home,
  output logic [NUM_FIELDS-1:0] inc,
  output logic                  flash_hr,
  output logic                  flash_min,
  output logic                  flash_sec,
  output logic                  show_alarm
);
  // field f is adjusted in mode f+1
  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_inc
    localparam logic [2:0] FIELD_MODE = 3'(f + 1);
    always_ff @(posedge clk) begin
      if (rst) inc[f] <= 1'b0;
      else     inc[f] <= adj & ~home & (mode == clk_mode_e'(FIELD_MODE));
    end
  end

  always_comb begin
    flash_hr   = (mode == MODE_T_HR)  || (mode == MODE_A_HR);
    flash_min  = (mode == MODE_T_MIN) || (mode == MODE_A_MIN);
    flash_sec  = (mode == MODE_T_SEC);
    show_alarm = (mode == MODE_A_HR)  || (mode == MODE_A_MIN);
  end
endmodule

// File: rtl/clkui_ctrl.sv
module clkui_ctrl
  import clkui_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic btn_mode,
  input  logic btn_adj,
  input  logic btn_home,
  output logic inc_time_hr,
  output logic inc_time_min,
  output logic inc_time_sec,
  output logic inc_alarm_hr,
  output logic inc_alarm_min,
  output logic flash_hr,
  output logic flash_min,
  output logic flash_sec,
  output logic show_alarm
);
  logic [NUM_BTN-1:0]    raw;
  logic [NUM_BTN-1:0]    press;
  logic [NUM_FIELDS-1:0] inc;
  clk_mode_e             mode_q;

  assign raw[BTN_MODE] = btn_mode;
  assign raw[BTN_ADJ]  = btn_adj;
  assign raw[BTN_HOME] = btn_home;

  for (genvar b = 0; b < NUM_BTN; b++) begin : g_btn
    clkui_btn_cond #(.STAGES(SYNC_STAGES)) u_cond (
      .clk(clk), .rst(rst), .btn_raw(raw[b]), .press(press[b])
    );
  end

  clkui_mode_fsm u_fsm (
    .clk(clk), .rst(rst),
    .step(press[BTN_MODE]), .home(press[BTN_HOME]),
    .mode(mode_q)
  );

  clkui_out_decode u_dec (
    .clk(clk), .rst(rst), .mode(mode_q),
    .adj(press[BTN_ADJ]), .home(press[BTN_HOME]),
    .inc(inc), .flash_hr(flash_hr), .flash_min(flash_min),
    .flash_sec(flash_sec), .show_alarm(show_alarm)
  );

  assign inc_time_hr   = inc[0];
  assign inc_time_min  = inc[1];
  assign inc_time_sec  = inc[2];
  assign inc_alarm_hr  = inc[3];
  assign inc_alarm_min = inc[4];
endmodule

// File: rtl/clkui_ctrl_chk.sv
module clkui_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic [2:0] mode_q,
  input logic       home_p,
  input logic [4:0] inc_v,
  input logic       flash_hr,
  input logic       flash_min,
  input logic       flash_sec,
  input logic       show_alarm
);
  a_r4_single_inc: assert property (@(posedge clk) disable iff (rst)
    $onehot0(inc_v));
  a_r5_run_no_inc: assert property (@(posedge clk) disable iff (rst)
    (mode_q == 3'd0) |=> (inc_v == 5'd0));
  a_r3_home_to_run: assert property (@(posedge clk) disable iff (rst)
    home_p |=> (mode_q == 3'd0));
  a_r2_step_order: assert property (@(posedge clk) disable iff (rst)
    (mode_q != $past(mode_q)) |->
      ((mode_q == 3'd0) || (mode_q == $past(mode_q) + 3'd1)));
  a_r2_mode_range: assert property (@(posedge clk) disable iff (rst)
    mode_q <= 3'd5);
  a_r7_one_flash: assert property (@(posedge clk) disable iff (rst)
    $onehot0({flash_hr, flash_min, flash_sec}));
  a_r8_alarm_no_sec: assert property (@(posedge clk) disable iff (rst)
    show_alarm |-> !flash_sec);
  a_r10_home_blocks_inc: assert property (@(posedge clk) disable iff (rst)
    home_p |=> (inc_v == 5'd0));
endmodule

bind clkui_ctrl clkui_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .mode_q(mode_q), .home_p(press[2]),
  .inc_v(inc), .flash_hr(flash_hr), .flash_min(flash_min),
  .flash_sec(flash_sec), .show_alarm(show_alarm)
);

// File: tb/clkui_ctrl_tb.sv
module clkui_ctrl_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic btn_mode = 1'b0, btn_adj = 1'b0, btn_home = 1'b0;
  logic inc_time_hr, inc_time_min, inc_time_sec, inc_alarm_hr, inc_alarm_min;
  logic flash_hr, flash_min, flash_sec, show_alarm;
  int checks = 0, failures = 0;
  int exp_mode = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  clkui_ctrl u_dut (
    .clk(clk), .rst(rst), .btn_mode(btn_mode), .btn_adj(btn_adj),
    .btn_home(btn_home), .inc_time_hr(inc_time_hr), .inc_time_min(inc_time_min),
    .inc_time_sec(inc_time_sec), .inc_alarm_hr(inc_alarm_hr),
    .inc_alarm_min(inc_alarm_min), .flash_hr(flash_hr), .flash_min(flash_min),
    .flash_sec(flash_sec), .show_alarm(show_alarm)
  );

  // {flash_hr, flash_min, flash_sec, show_alarm} per mode
  function automatic logic [3:0] exp_flags(int m);
    case (m)
      1: return 4'b1000;
      2: return 4'b0100;
      3: return 4'b0010;
      4: return 4'b1001;
      5: return 4'b0101;
      default: return 4'b0000;
    endcase
  endfunction

  // bit f set for field of mode f+1
  function automatic logic [4:0] exp_inc(int m, logic a, logic h);
    if (!a || h || m == 0) return 5'd0;
    return 5'(1 << (m - 1));
  endfunction

  function automatic int next_mode(int m, logic s, logic h);
    if (h) return 0;
    if (s) return (m == 5) ? 0 : m + 1;
    return m;
  endfunction

  task automatic chk(string rq, logic [8:0] act, logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", rq, act, exp);
    end
  endtask

  function automatic logic [8:0] outs();
    return {inc_alarm_min, inc_alarm_hr, inc_time_sec, inc_time_min, inc_time_hr,
            flash_hr, flash_min, flash_sec, show_alarm};
  endfunction

  task automatic apply(logic s, logic a, logic h, int hold, string rq);
    logic [4:0] ei;
    int nm;
    @(negedge clk);
    btn_mode = s; btn_adj = a; btn_home = h;
    ei = exp_inc(exp_mode, a, h);
    nm = next_mode(exp_mode, s, h);
    repeat (3) @(posedge clk);
    @(negedge clk);
    exp_mode = nm;
    chk(rq, outs(), {ei, exp_flags(exp_mode)});
    @(negedge clk);
    chk({rq, " R6"}, outs(), {5'd0, exp_flags(exp_mode)});
    repeat (hold) @(negedge clk);
    chk({rq, " R6 hold"}, outs(), {5'd0, exp_flags(exp_mode)});
    btn_mode = 1'b0; btn_adj = 1'b0; btn_home = 1'b0;
    repeat (4) @(negedge clk);
    chk({rq, " idle"}, outs(), {5'd0, exp_flags(exp_mode)});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int seed = 32'h5eed;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    chk("R1 in reset", outs(), 9'd0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 after reset", outs(), 9'd0);

    apply(1'b0, 1'b1, 1'b0, 0, "R5 adj in run");
    for (int i = 0; i < 6; i++) begin
      apply(1'b0, 1'b1, 1'b0, 0, "R4 R7 R8 adj per mode");
      apply(1'b1, 1'b0, 1'b0, 0, "R2 step order");
    end
    apply(1'b1, 1'b0, 1'b0, 20, "R6 held mode");
    apply(1'b1, 1'b0, 1'b0, 0, "R2 step");
    apply(1'b1, 1'b1, 1'b0, 0, "R9 adj with step");
    apply(1'b0, 1'b1, 1'b1, 0, "R10 home with adj");
    apply(1'b1, 1'b0, 1'b0, 0, "R2 step");
    apply(1'b1, 1'b0, 1'b0, 0, "R2 step");
    apply(1'b1, 1'b0, 1'b1, 0, "R3 home beats mode");
    for (int i = 0; i < 120; i++) begin
      logic [2:0] r;
      r = 3'($urandom_range(0, 7));
      if (r[2] && ($urandom_range(0, 3) != 0)) r[2] = 1'b0;
      apply(r[0], r[1], r[2], int'($urandom_range(0, 3)), "R2 R3 R4 R9 random");
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule